// File: doc/BRIEF.md
# Frame Aperture Sequential Access Controller

This block sits between a small frame-processing pipeline and a shared, synchronously read RAM. A host programs, over a 32-bit register bus, where the input frame starts, where the output frame goes, how many words the input frame holds and how many words the output region may take. The host then writes a start command. From then on the pipeline never handles addresses. It issues read-in commands, which pull the next words of the input frame, and write-out commands, which push words into the next free slots of the output region, as if that region were a FIFO.

Every command moves one to four consecutive words, one RAM access per cycle, and holds the pipeline through a busy flag until the last word has been transferred. The block checks each command against the region bounds before it makes any access. A command that would cross a bound makes no access. It records which region was overrun, raises an interrupt and parks the unit until the host re-initialises it. A finish command closes the frame: the unit raises a completion interrupt and drops back to idle, so the host can collect the output frame.

The controller has four states. IDLE leaves only on start, to RUN. RUN goes to DONE on a finish command, to FAULT on an out-of-bounds command, and to IDLE on re-initialisation. DONE lasts one cycle and then returns to IDLE. FAULT leaves only on re-initialisation, to IDLE.

Top module: `frame_aperture_ctrl`

## Requirements
- R1: After reset the state is IDLE, `irq`, `mem_en` and `cmd_busy` are low, and the status register (address 5) reads zero.
- R2: Writing 1 to bit 0 of the control register (address 4) moves IDLE to RUN on the next edge and zeroes both word indexes. A start written in any other state has no effect.
- R3: A read-in command (`cmd_op`=0) with `cmd_count`=n accesses RAM on n+1 consecutive cycles, at input base + read index upward. In the cycle after each access, `rd_valid` is high and `rd_data` carries the RAM word.
- R4: A write-out command (`cmd_op`=1) writes n+1 consecutive words at output base + write index upward. It pulses `wr_take` on each one and stores `out_data` as presented in that cycle.
- R5: `cmd_busy` rises in the cycle after a command is accepted and stays high until the last word (and, for reads, its data) has been delivered. A command presented while busy is ignored. RAM is accessed only in RUN.
- R6: A read-in that would take the read index past the frame length (address 2) makes no access. It enters FAULT with cause 01 and sets the fault interrupt.
- R7: A write-out that would take the write index past the output length (address 3) makes no access. It enters FAULT with cause 10 and sets the fault interrupt.
- R8: In FAULT, commands and start are ignored. Only writing 1 to control bit 1 (re-initialise) leaves it, to IDLE, and that write also clears the cause.
- R9: A finish command (`cmd_op`=2) in RUN enters DONE for exactly one cycle, then IDLE, and sets the done interrupt.
- R10: Status reads [1:0] state (IDLE 0, RUN 1, DONE 2, FAULT 3), [3:2] fault cause, [4] done interrupt, [5] fault interrupt, and from bit 16 upward the output word count.
- R11: Writing 1 to status bit 4 or 5 clears that interrupt bit. `irq` is the OR of both bits.
- R12: Commands presented outside RUN cause no RAM access and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (0 in base, 1 out base, 2 frame length, 3 out length, 4 control, 5 status) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 read-in, 1 write-out, 2 finish, 3 ignored |
| cmd_count | input | 2 | Words to move minus one |
| cmd_busy | output | 1 | Transfer in progress; pipeline stalls |
| rd_data | output | 32 | Word read from the input region |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| out_data | input | 32 | Word to store in the output region |
| wr_take | output | 1 | `out_data` is stored this cycle |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, one cycle after the access |
| irq | output | 1 | Done or fault interrupt pending |

## Verification
The assertions assume that the host leaves the base and length registers unchanged while a burst is in flight. They also assume that the RAM returns read data exactly one cycle after an access, and that the pipeline presents a command only for as long as it intends one. The stimulus sets up the region registers only while the unit is idle or faulted. It drives commands for a single cycle, except in the one test that deliberately holds a command across a busy cycle. The bench RAM model has the one-cycle read latency.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } fa_state_t;

    localparam logic [1:0] OP_READ   = 2'd0;
    localparam logic [1:0] OP_WRITE  = 2'd1;
    localparam logic [1:0] OP_FINISH = 2'd2;

    localparam logic [2:0] RA_IN_BASE  = 3'd0;
    localparam logic [2:0] RA_OUT_BASE = 3'd1;
    localparam logic [2:0] RA_FLEN     = 3'd2;
    localparam logic [2:0] RA_OLEN     = 3'd3;
    localparam logic [2:0] RA_CTRL     = 3'd4;
    localparam logic [2:0] RA_STATUS   = 3'd5;

    localparam int CTRL_START_BIT  = 0;
    localparam int CTRL_REINIT_BIT = 1;
    localparam int ST_DONE_BIT     = 4;
    localparam int ST_FAULT_BIT    = 5;
    localparam int ST_COUNT_LSB    = 16;

    localparam logic [1:0] CAUSE_IN  = 2'b01;
    localparam logic [1:0] CAUSE_OUT = 2'b10;
endpackage

// File: rtl/fa_cfg.sv
module fa_cfg
    import fa_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic [AW-1:0] in_base,
    output logic [AW-1:0] out_base,
    output logic [AW:0]   frame_len,
    output logic [AW:0]   out_len,
    output logic          start_req,
    output logic          reinit_req,
    input  logic          done_ev,
    input  logic          fault_ev,
    input  logic [1:0]    fault_cause,
    input  fa_state_t     state_in,
    input  logic [AW:0]   out_count,
    output logic          irq_done,
    output logic          irq_fault
);
    logic [1:0] cause_q;
    logic       wdata_unused;

    assign wdata_unused = ^wdata[31:AW+1];
    assign start_req  = wr_en && addr == RA_CTRL && wdata[CTRL_START_BIT];
    assign reinit_req = wr_en && addr == RA_CTRL && wdata[CTRL_REINIT_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_base   <= '0;
            out_base  <= '0;
            frame_len <= '0;
            out_len   <= '0;
            cause_q   <= '0;
            irq_done  <= 1'b0;
            irq_fault <= 1'b0;
        end else begin
            if (wr_en) begin
                case (addr)
                    RA_IN_BASE:  in_base   <= wdata[AW-1:0];
                    RA_OUT_BASE: out_base  <= wdata[AW-1:0];
                    RA_FLEN:     frame_len <= wdata[AW:0];
                    RA_OLEN:     out_len   <= wdata[AW:0];
                    default: ;
                endcase
            end
            if (done_ev)
                irq_done <= 1'b1;
            else if (wr_en && addr == RA_STATUS && wdata[ST_DONE_BIT])
                irq_done <= 1'b0;
            if (fault_ev)
                irq_fault <= 1'b1;
            else if (wr_en && addr == RA_STATUS && wdata[ST_FAULT_BIT])
                irq_fault <= 1'b0;
            if (reinit_req)
                cause_q <= '0;
            else if (fault_ev)
                cause_q <= fault_cause;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_IN_BASE:  rdata[AW-1:0] = in_base;
            RA_OUT_BASE: rdata[AW-1:0] = out_base;
            RA_FLEN:     rdata[AW:0]   = frame_len;
            RA_OLEN:     rdata[AW:0]   = out_len;
            RA_STATUS: begin
                rdata[1:0]                           = state_in;
                rdata[3:2]                           = cause_q;
                rdata[ST_DONE_BIT]                   = irq_done;
                rdata[ST_FAULT_BIT]                  = irq_fault;
                rdata[ST_COUNT_LSB+AW:ST_COUNT_LSB]  = out_count;
            end
            default: rdata = '0;
        endcase
    end

    // R11
    w1c_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_STATUS && wdata[ST_DONE_BIT] && !done_ev) |=> !irq_done);
endmodule

// File: rtl/fa_stream.sv
module fa_stream #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          launch,
    input  logic          launch_wr,
    input  logic [2:0]    launch_cnt,
    input  logic [AW-1:0] in_base,
    input  logic [AW-1:0] out_base,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          rd_valid,
    output logic          wr_take,
    output logic          busy,
    output logic [AW:0]   rd_idx,
    output logic [AW:0]   wr_idx
);
    logic [2:0] remain_q;
    logic       dir_wr_q;

    assign mem_en   = remain_q != 3'd0;
    assign mem_we   = mem_en && dir_wr_q;
    assign wr_take  = mem_we;
    assign mem_addr = dir_wr_q ? out_base + wr_idx[AW-1:0] : in_base + rd_idx[AW-1:0];
    assign busy     = mem_en || rd_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            dir_wr_q <= 1'b0;
            rd_valid <= 1'b0;
            rd_idx   <= '0;
            wr_idx   <= '0;
        end else if (clear) begin
            remain_q <= '0;
            rd_valid <= 1'b0;
            rd_idx   <= '0;
            wr_idx   <= '0;
        end else begin
            rd_valid <= mem_en && !dir_wr_q;
            if (launch) begin
                remain_q <= launch_cnt;
                dir_wr_q <= launch_wr;
            end else if (mem_en) begin
                remain_q <= remain_q - 3'd1;
                if (dir_wr_q)
                    wr_idx <= wr_idx + 1'b1;
                else
                    rd_idx <= rd_idx + 1'b1;
            end
        end
    end

    // R3 R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(remain_q) > 3'd1) |-> mem_addr == $past(mem_addr) + 1'b1);
    // R3
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(mem_en && !mem_we));
endmodule

// File: rtl/frame_aperture_ctrl.sv
module frame_aperture_ctrl
    import fa_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [1:0]    cmd_count,
    output logic          cmd_busy,
    output logic [31:0]   rd_data,
    output logic          rd_valid,
    input  logic [31:0]   out_data,
    output logic          wr_take,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          irq
);
    localparam int EW = AW + 2;

    fa_state_t     state_q, state_d;
    logic [AW-1:0] in_base, out_base;
    logic [AW:0]   frame_len, out_len, rd_idx, wr_idx;
    logic          start_req, reinit_req, irq_done, irq_fault;
    logic          accept, over_rd, over_wr, launch, fault_ev, done_ev, clear;
    logic [2:0]    cnt3;
    logic [EW-1:0] rd_end, wr_end;
    logic [1:0]    cause;

    fa_cfg #(.AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .in_base(in_base),
        .out_base(out_base), .frame_len(frame_len), .out_len(out_len),
        .start_req(start_req), .reinit_req(reinit_req), .done_ev(done_ev),
        .fault_ev(fault_ev), .fault_cause(cause), .state_in(state_q),
        .out_count(wr_idx), .irq_done(irq_done), .irq_fault(irq_fault)
    );

    fa_stream #(.AW(AW)) u_stream (
        .clk(clk), .rst_n(rst_n), .clear(clear), .launch(launch),
        .launch_wr(cmd_op == OP_WRITE), .launch_cnt(cnt3),
        .in_base(in_base), .out_base(out_base), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .rd_valid(rd_valid),
        .wr_take(wr_take), .busy(cmd_busy), .rd_idx(rd_idx), .wr_idx(wr_idx)
    );

    assign rd_data   = mem_rdata;
    assign mem_wdata = out_data;
    assign irq       = irq_done || irq_fault;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command decode and events
    always_comb begin
        cnt3     = {1'b0, cmd_count} + 3'd1;
        rd_end   = {1'b0, rd_idx} + {{(EW-3){1'b0}}, cnt3};
        wr_end   = {1'b0, wr_idx} + {{(EW-3){1'b0}}, cnt3};
        over_rd  = rd_end > {1'b0, frame_len};
        over_wr  = wr_end > {1'b0, out_len};
        accept   = cmd_valid && !cmd_busy && state_q == ST_RUN && !reinit_req;
        launch   = accept && ((cmd_op == OP_READ && !over_rd) ||
                              (cmd_op == OP_WRITE && !over_wr));
        fault_ev = accept && ((cmd_op == OP_READ && over_rd) ||
                              (cmd_op == OP_WRITE && over_wr));
        done_ev  = accept && cmd_op == OP_FINISH;
        cause    = (cmd_op == OP_READ) ? CAUSE_IN : CAUSE_OUT;
        clear    = reinit_req || (start_req && state_q == ST_IDLE);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_req && !reinit_req) state_d = ST_RUN;
            ST_RUN: begin
                if (reinit_req)    state_d = ST_IDLE;
                else if (fault_ev) state_d = ST_FAULT;
                else if (done_ev)  state_d = ST_DONE;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: if (reinit_req) state_d = ST_IDLE;
        endcase
    end

    // R5
    mem_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> state_q == ST_RUN);
    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && !reinit_req) |=> state_q == ST_FAULT);
    // R9
    done_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DONE |=> state_q == ST_IDLE);
    // R6 R7
    fault_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_fault) |-> state_q == ST_FAULT && !mem_en);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_req) |=> state_q == ST_IDLE);
endmodule

// File: tb/frame_aperture_ctrl_test.sv
module frame_aperture_ctrl_test;
    localparam int AW = 8;
    localparam logic [7:0] IB = 8'h20;
    localparam logic [7:0] OB = 8'h80;
    // {op[1:0], words[2:0], exp_state[1:0]}
    localparam logic [6:0] VEC [0:4] = '{
        {2'd0, 3'd2, 2'd1},
        {2'd1, 3'd3, 2'd1},
        {2'd0, 3'd4, 2'd1},
        {2'd1, 3'd2, 2'd1},
        {2'd2, 3'd1, 2'd2}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, cmd_valid = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata, rd_data, out_data = '0, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [1:0] cmd_op = '0, cmd_count = '0;
    logic cmd_busy, rd_valid, wr_take, mem_en, mem_we, irq;
    logic [AW-1:0] mem_addr;
    logic [31:0] ram [0:255];
    int errors = 0, checks = 0, exp_rd = 0, exp_wr = 0;
    logic [7:0] pend = '0;
    logic [31:0] sv;
    int words, bad;

    always #5 clk = ~clk;

    frame_aperture_ctrl #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_count(cmd_count), .cmd_busy(cmd_busy),
        .rd_data(rd_data), .rd_valid(rd_valid), .out_data(out_data),
        .wr_take(wr_take), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq(irq)
    );

    function automatic logic [31:0] pat(input logic [7:0] a);
        return 32'h5A5A0000 + {24'd0, a};
    endfunction

    function automatic logic [31:0] st(input int s, input int c, input int dn,
                                       input int ft, input int n);
        return 32'((n << 16) | (ft << 5) | (dn << 4) | (c << 2) | s);
    endfunction

    always @(posedge clk)
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr];
        end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic status(output logic [31:0] d);
        cfg_addr = 3'd5;
        #1 d = cfg_rdata;
    endtask

    task automatic run_cmd(input logic [1:0] op, input int cnt, output int w, output int b);
        w = 0; b = 0;
        cmd_valid = 1'b1; cmd_op = op; cmd_count = 2'(cnt - 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op == 2'd2) return;
        for (int k = 0; k < 7; k++) begin
            if (rd_valid && rd_data !== pat(pend)) b++;
            if (mem_en) begin
                w++;
                if (mem_we) begin
                    if (mem_addr !== 8'(OB + exp_wr)) b++;
                    out_data = 32'hC0DE0000 + 32'(exp_wr);
                    exp_wr++;
                end else begin
                    if (mem_addr !== 8'(IB + exp_rd)) b++;
                    pend = mem_addr;
                    exp_rd++;
                end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = pat(8'(i));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        status(sv);
        chk("R1 status", sv, 32'd0);
        chk("R1 outputs", {29'd0, irq, mem_en, cmd_busy}, 32'd0);

        // R12 command while IDLE
        run_cmd(2'd0, 1, words, bad);
        chk("R12 idle cmd words", 32'(words), 32'd0);

        cfg_wr(3'd0, {24'd0, IB});
        cfg_wr(3'd1, {24'd0, OB});
        cfg_wr(3'd2, 32'd6);
        cfg_wr(3'd3, 32'd5);
        cfg_wr(3'd4, 32'd1);
        status(sv);
        chk("R2 start to RUN", sv, st(1, 0, 0, 0, 0));

        // table of commands
        for (int i = 0; i < 5; i++) begin
            run_cmd(VEC[i][6:5], int'(VEC[i][4:2]), words, bad);
            if (VEC[i][6:5] != 2'd2) begin
                chk(VEC[i][6:5] == 2'd0 ? "R3 read words" : "R4 write words",
                    32'(words), 32'(VEC[i][4:2]));
                chk("R3 R4 addr/data", 32'(bad), 32'd0);
            end
            status(sv);
            chk("R9 R10 state", {30'd0, sv[1:0]}, {30'd0, VEC[i][1:0]});
        end
        @(negedge clk);
        status(sv);
        chk("R9 DONE to IDLE with done irq", sv, st(0, 0, 1, 0, 5));
        chk("R11 irq pin", {31'd0, irq}, 32'd1);
        for (int k = 0; k < 5; k++)
            chk("R4 stored word", ram[8'(OB + k)], 32'hC0DE0000 + 32'(k));
        cfg_wr(3'd5, 32'h10);
        status(sv);
        chk("R11 done w1c", sv, st(0, 0, 0, 0, 5));
        chk("R11 irq cleared", {31'd0, irq}, 32'd0);

        // R5 command held across a busy cycle
        cfg_wr(3'd4, 32'd1);
        exp_rd = 0; exp_wr = 0;
        status(sv);
        chk("R2 indexes cleared", sv, st(1, 0, 0, 0, 0));
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_count = 2'd0;
        out_data = 32'hC0DE0000;
        @(negedge clk);
        chk("R5 busy after accept", {31'd0, cmd_busy}, 32'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        exp_wr = 1;
        status(sv);
        chk("R5 busy command ignored", sv, st(1, 0, 0, 0, 1));

        // R6 input overrun
        run_cmd(2'd0, 4, words, bad);
        chk("R3 read 4", 32'(words), 32'd4);
        run_cmd(2'd0, 3, words, bad);
        chk("R6 no access", 32'(words), 32'd0);
        status(sv);
        chk("R6 fault cause in", sv, st(3, 1, 0, 1, 1));

        // R8 fault holds
        cfg_wr(3'd4, 32'd1);
        run_cmd(2'd1, 1, words, bad);
        chk("R8 cmd in fault words", 32'(words), 32'd0);
        status(sv);
        chk("R8 fault held", sv, st(3, 1, 0, 1, 1));
        cfg_wr(3'd4, 32'd2);
        status(sv);
        chk("R8 reinit to IDLE", sv, st(0, 0, 0, 1, 0));
        cfg_wr(3'd5, 32'h20);
        chk("R11 fault w1c irq", {31'd0, irq}, 32'd0);

        // R7 output overrun
        cfg_wr(3'd4, 32'd1);
        exp_rd = 0; exp_wr = 0;
        run_cmd(2'd1, 4, words, bad);
        chk("R4 write 4", 32'(words), 32'd4);
        run_cmd(2'd1, 2, words, bad);
        chk("R7 no access", 32'(words), 32'd0);
        status(sv);
        chk("R7 fault cause out", sv, st(3, 2, 0, 1, 4));
        cfg_wr(3'd4, 32'd2);
        status(sv);
        chk("R8 reinit", {30'd0, sv[1:0]}, 32'd0);
        summary();
    end
endmodule